// File: doc/BRIEF.md
# Audio controller global control and status registers

This block holds the two controller-wide 32-bit registers of a three-channel audio DMA engine: a control word and a status word. Software reaches them over a simple single-cycle register bus. The status word has four kinds of bits. A few are set and cleared by hardware. Some are sticky bits that hardware sets and software clears by writing ones. Some can only be set by software. The rest are read-only.

The three DMA channels (PCM capture, PCM playback, microphone capture) each drive a level interrupt condition into the block. The block mirrors each condition into its own status flag. The OR of the three flags drives a single interrupt output.

The control word stores six bits, two of which request a codec cold or warm reset. The link that would carry out such a reset is not part of this block. For that reason, a control write that requests either reset is dropped whole. Status reads always report the primary codec as ready.

Top module: `gcs_top`

## Requirements
- R1: After synchronous reset the control register reads 0, the status register reads 0x0000_0100, and `irq` is 0.
- R2: A control write (offset 0x2C) whose data has bit 1 and bit 2 both clear stores the data masked to bits 5:0. Bits 31:6 read back as 0.
- R3: A control write whose data has bit 1 (cold reset request) or bit 2 (warm reset request) set leaves the stored control value unchanged.
- R4: Every status read (offset 0x30) returns bit 8 (primary codec ready) as 1.
- R5: Status bits 17:16 are software-set: a written 1 sets the bit and a written 0 leaves it unchanged. Only reset clears them.
- R6: Status bits 0, 10, 11 and 15 are sticky. They are set by `evt_set[0]`, `evt_set[1]`, `evt_set[2]` and `evt_set[3]` respectively, and cleared by writing 1 to the bit. Writing 0 leaves the bit unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R7: Status bits 5, 6 and 7 show `ch_irq[0]` (PCM capture), `ch_irq[1]` (PCM playback) and `ch_irq[2]` (mic capture), sampled at the previous clock edge.
- R8: Status writes have no effect on read-only bits 14:12, 9:5, 2 and 1, on reserved bits 4:3, or on bits 31:18.
- R9: `irq` is the OR of status bits 7:5. It is high in the cycle after any `ch_irq` input was high at a clock edge.
- R10: A read returns its data on `bus_rdata` in the cycle after `bus_rd` is sampled. An offset other than 0x2C or 0x30 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset within the register space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_set | input | 4 | Hardware set pulses for the sticky status bits |
| ch_irq | input | 3 | Channel interrupt conditions: capture, playback, mic |
| irq | output | 1 | Combined interrupt output |

## Verification
Several properties are checked on every cycle. A dropped reset-request write leaves the control value stable, and an accepted write stores the low six bits. The channel flags and `irq` track the inputs with one cycle of lag. A sticky bit always reflects a set pulse, and the software-set bits never fall. Every status read shows codec-ready, and unmapped offsets read 0. Other behaviours only show up through the bench's scenarios, which compare full read words against expected values: the exact clear-by-one pattern, a set and a clear landing in the same cycle, and writes to read-only and reserved bits having no effect.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  localparam int DATA_W   = 32;
  localparam int CTRL_W   = 6;
  localparam int STAT_W   = 18;
  localparam int COLD_BIT = 1;
  localparam int WARM_BIT = 2;
  localparam int N_CH     = 3;
  localparam int FLAG_LSB = 5;
  localparam int READY_BIT = 8;
  localparam int N_STICKY = 4;
  localparam int SWSET_LSB = 16;
  localparam int SWSET_W  = 2;

  // status bit position of each sticky bit, indexed by its set input
  function automatic int sticky_pos(input int i);
    case (i)
      0: sticky_pos = 0;
      1: sticky_pos = 10;
      2: sticky_pos = 11;
      default: sticky_pos = 15;
    endcase
  endfunction
endpackage

// File: rtl/gcs_ctrl.sv
module gcs_ctrl
  import gcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic reset_req;
  assign reset_req = wdata[COLD_BIT] | wdata[WARM_BIT];

  always_ff @(posedge clk) begin
    if (rst) ctrl_o <= '0;
    else if (we && !reset_req) ctrl_o <= wdata;
  end

  p_reset_req_dropped_r3: assert property (@(posedge clk) disable iff (rst)
    (we && (wdata[COLD_BIT] || wdata[WARM_BIT])) |=> $stable(ctrl_o));
  p_plain_write_stored_r2: assert property (@(posedge clk) disable iff (rst)
    (we && !wdata[COLD_BIT] && !wdata[WARM_BIT]) |=> ctrl_o == $past(wdata));
endmodule

// File: rtl/gcs_status.sv
module gcs_status
  import gcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [STAT_W-1:0]   wdata,
  input  logic [N_STICKY-1:0] evt_set,
  input  logic [N_CH-1:0]     ch_irq,
  output logic [STAT_W-1:0]   stat_o,
  output logic                irq_o
);
  logic [N_STICKY-1:0] sticky_q;
  logic [SWSET_W-1:0]  swset_q;
  logic [N_CH-1:0]     flag_q;
  logic                unused_wbits;
  assign unused_wbits = ^wdata;

  genvar gi;
  generate
    for (gi = 0; gi < N_STICKY; gi++) begin : g_sticky
      localparam int POS = sticky_pos(gi);
      always_ff @(posedge clk) begin
        if (rst) sticky_q[gi] <= 1'b0;
        else if (evt_set[gi]) sticky_q[gi] <= 1'b1;
        else if (we && wdata[POS]) sticky_q[gi] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      swset_q <= '0;
      flag_q  <= '0;
    end else begin
      if (we) swset_q <= swset_q | wdata[SWSET_LSB +: SWSET_W];
      flag_q <= ch_irq;
    end
  end

  always_comb begin
    stat_o = '0;
    stat_o[SWSET_LSB +: SWSET_W] = swset_q;
    stat_o[FLAG_LSB +: N_CH]     = flag_q;
    stat_o[READY_BIT]            = 1'b1;
    for (int i = 0; i < N_STICKY; i++) stat_o[sticky_pos(i)] = sticky_q[i];
  end

  assign irq_o = |flag_q;

  p_flags_follow_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> flag_q == $past(ch_irq));
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_o == (|$past(ch_irq)));
  p_sticky_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((sticky_q & $past(evt_set)) == $past(evt_set)));
  p_sticky_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (!we && evt_set == '0) |=> $stable(sticky_q));
  p_swset_never_falls_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((swset_q & $past(swset_q)) == $past(swset_q)));
endmodule

// File: rtl/gcs_top.sv
module gcs_top
  import gcs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFF = 'h2C,
  parameter int STAT_OFF = 'h30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [N_STICKY-1:0] evt_set,
  input  logic [N_CH-1:0]     ch_irq,
  output logic                irq
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFF);

  logic sel_ctrl, sel_stat;
  logic [CTRL_W-1:0] ctrl_q;
  logic [STAT_W-1:0] stat_w;
  logic unused_hi;

  assign sel_ctrl  = (bus_addr == CTRL_A);
  assign sel_stat  = (bus_addr == STAT_A);
  assign unused_hi = ^bus_wdata[DATA_W-1:STAT_W];

  gcs_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .we(bus_wr && sel_ctrl),
    .wdata(bus_wdata[CTRL_W-1:0]),
    .ctrl_o(ctrl_q)
  );

  gcs_status u_stat (
    .clk(clk), .rst(rst),
    .we(bus_wr && sel_stat),
    .wdata(bus_wdata[STAT_W-1:0]),
    .evt_set(evt_set),
    .ch_irq(ch_irq),
    .stat_o(stat_w),
    .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      if (sel_ctrl)      bus_rdata <= DATA_W'(ctrl_q);
      else if (sel_stat) bus_rdata <= DATA_W'(stat_w);
      else               bus_rdata <= '0;
    end
  end

  p_ready_on_read_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel_stat) |=> bus_rdata[READY_BIT]);
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !sel_ctrl && !sel_stat) |=> bus_rdata == '0);
endmodule

// File: tb/tb_gcs_top.sv
module tb_gcs_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  evt_set = '0;
  logic [2:0]  ch_irq = '0;
  logic        irq;

  localparam logic [7:0] A_CTRL = 8'h2C, A_STAT = 8'h30;

  gcs_top dut (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_set(evt_set), .ch_irq(ch_irq), .irq(irq));

  always #5 clk = ~clk;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  logic rd_q = 1'b0;
  bit done = 0;

  always @(posedge clk) rd_q <= bus_rd;

  // monitor: compare each returned read word with the queued expectation
  always @(negedge clk) begin
    if (rd_q && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (bus_rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq=%b expected=%b", tag, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(A_CTRL, 32'h0, "R1 ctrl reset");
    rd(A_STAT, 32'h100, "R1 status reset");
    chk_irq(1'b0, "R1 irq reset");
    // R2 stores masked value
    wr(A_CTRL, 32'h39);
    rd(A_CTRL, 32'h39, "R2 plain ctrl write");
    wr(A_CTRL, 32'hFFFF_FFC1);
    rd(A_CTRL, 32'h01, "R2 upper bits masked");
    // R3 reset requests dropped
    wr(A_CTRL, 32'h3F);
    rd(A_CTRL, 32'h01, "R3 both reset bits");
    wr(A_CTRL, 32'h04);
    rd(A_CTRL, 32'h01, "R3 warm reset bit");
    wr(A_CTRL, 32'h02);
    rd(A_CTRL, 32'h01, "R3 cold reset bit");
    // R7 / R9 channel flags
    @(negedge clk); ch_irq = 3'b010;
    @(negedge clk); chk_irq(1'b1, "R9 playback irq");
    rd(A_STAT, 32'h140, "R7 playback flag");
    wr(A_STAT, 32'h0000_00E0);
    rd(A_STAT, 32'h140, "R8 flags not writable");
    @(negedge clk); ch_irq = 3'b000;
    @(negedge clk); chk_irq(1'b0, "R9 irq drops");
    rd(A_STAT, 32'h100, "R7 flags cleared by input");
    @(negedge clk); ch_irq = 3'b101;
    @(negedge clk); chk_irq(1'b1, "R9 capture and mic irq");
    rd(A_STAT, 32'h1A0, "R7 capture and mic flags");
    @(negedge clk); ch_irq = 3'b000;
    // R5 software-set bits
    wr(A_STAT, 32'h0001_0000);
    rd(A_STAT, 32'h0001_0100, "R5 set bit16");
    wr(A_STAT, 32'h0002_0000);
    rd(A_STAT, 32'h0003_0100, "R5 set bit17 keeps bit16");
    wr(A_STAT, 32'h0);
    rd(A_STAT, 32'h0003_0100, "R5 zero write keeps bits");
    // R6 sticky bits
    @(negedge clk); evt_set = 4'hF;
    @(negedge clk); evt_set = 4'h0;
    rd(A_STAT, 32'h0003_8D01, "R6 all sticky set");
    wr(A_STAT, 32'h0);
    rd(A_STAT, 32'h0003_8D01, "R6 zero write keeps sticky");
    wr(A_STAT, 32'h0000_0401);
    rd(A_STAT, 32'h0003_8900, "R6 clear bits 10 and 0");
    // R8 read-only, reserved and high bits
    wr(A_STAT, 32'hFFFC_721E);
    rd(A_STAT, 32'h0003_8900, "R8 read-only bits ignored");
    // R6 set wins over clear
    @(negedge clk); bus_addr = A_STAT; bus_wdata = 32'h8000; bus_wr = 1'b1; evt_set = 4'h8;
    @(negedge clk); bus_wr = 1'b0; evt_set = 4'h0;
    rd(A_STAT, 32'h0003_8900, "R6 set beats clear");
    wr(A_STAT, 32'h0000_8800);
    rd(A_STAT, 32'h0003_0100, "R6 clear bits 15 and 11");
    // R10 unmapped offset and R4
    rd(8'h00, 32'h0, "R10 unmapped offset");
    rd(8'h34, 32'h0, "R10 unmapped offset 0x34");
    rd(A_CTRL, 32'h01, "R10 ctrl after traffic");
    chk_irq(1'b0, "R9 idle irq");
    rd(A_STAT, 32'h0003_0100, "R4 ready bit still set");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule